// File: doc/BRIEF.md
# Buffered PWM Duty Sequencer

This block supplies a PWM compare stage with a fresh duty value at every switching-period update event, rather than holding one value for a whole control period. Once per control period a host loads a short table of precomputed duty commands. Each table entry is one forward-projected command for one switching period. The block replays the table one entry per update strobe, in the order the host wrote it.

Storage is split into two banks. The host always writes the bank that is not being played. When the host raises a commit pulse, the block latches a table length, and the banks swap at the next update strobe. If playback reaches the end of the table before a new commit, the block keeps the last duty value and raises a sticky starvation flag. Every value presented is limited to the current PWM period count. The output changes only on an update strobe.

Top module: `pwm_duty_seq`

## Requirements
- R1: After reset, `duty` is 0, `underrun` is 0 and `active_bank` is 0.
- R2: A write with `wr_en` high stores `wr_data` at entry `wr_addr` of the bank that is not active (bank index `~active_bank`). Writes never change the entries being played from the active bank.
- R3: A commit is held pending until the next `upd_evt`. On that strobe `active_bank` toggles and `duty` takes entry 0 of the newly active bank.
- R4: Each later `upd_evt` presents the next entry, in ascending address order (1, 2, ...), until the committed length has been played.
- R5: `duty` changes only in the cycle after an `upd_evt`. Between strobes it holds, whatever happens on the write, commit or period inputs.
- R6: An `upd_evt` that finds every entry already played leaves `duty` at its last value and sets `underrun` to 1.
- R7: `underrun` stays at 1 across further strobes and idle cycles. It is cleared only by the update strobe that applies a commit with a nonzero length.
- R8: The presented value is min(entry, `period_cnt`), with `period_cnt` sampled on the same `upd_evt`.
- R9: A `commit` in the same cycle as `upd_evt` is applied on that strobe.
- R10: A committed length of 0 still swaps banks on the next strobe, but plays no entry. `duty` holds and `underrun` becomes 1.
- R11: The length is sampled from `commit_len` in the commit cycle, and later changes of `commit_len` are ignored. A length above the bank depth (16 by default) plays the full bank.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Host write strobe into the inactive bank |
| wr_addr | input | AW (4) | Entry index within the bank |
| wr_data | input | DW (16) | Unsigned duty command |
| commit | input | 1 | Request a bank swap at the next update strobe |
| commit_len | input | LW (5) | Entries to play from the committed bank |
| upd_evt | input | 1 | PWM update-event strobe |
| period_cnt | input | DW (16) | PWM period count used as the clamp limit |
| duty | output | DW (16) | Active duty value |
| underrun | output | 1 | Sticky starvation flag |
| active_bank | output | 1 | Index of the bank being played |

## Verification
The hardest situation to reach from the ports is a commit that meets a strobe in the same cycle, especially right after a starved period. In that case the swap, the pointer reload and the flag clear must all happen in a single edge. The stimulus first drains a table into underrun. It then raises `commit` and `upd_evt` together, and later commits a zero length and an oversized length, so that the pointer reload meets both edges of the length range.

// File: rtl/dseq_pkg.sv
package dseq_pkg;
  typedef enum logic {
    ACT_HOLD = 1'b0,
    ACT_LOAD = 1'b1
  } dseq_act_e;
endpackage

// File: rtl/dseq_banks.sv
module dseq_banks #(
  parameter int DW    = 16,
  parameter int DEPTH = 16,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic          wbank,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic          rbank,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] rd_by_bank [2];

  for (genvar b = 0; b < 2; b++) begin : g_bank
    logic [DW-1:0] store [DEPTH];
    logic          bank_we;

    assign bank_we = we && (wbank == 1'(b));

    always_ff @(posedge clk) begin
      if (bank_we) store[waddr] <= wdata;
    end

    assign rd_by_bank[b] = store[raddr];
  end

  assign rdata = rbank ? rd_by_bank[1] : rd_by_bank[0];
endmodule

// File: rtl/dseq_ctrl.sv
module dseq_ctrl
  import dseq_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int AW    = $clog2(DEPTH),
  parameter int LW    = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          commit,
  input  logic [LW-1:0] commit_len,
  input  logic          upd_evt,
  output dseq_act_e     act,
  output logic          rd_bank,
  output logic [AW-1:0] rd_addr,
  output logic          act_bank,
  output logic          underrun
);
  localparam logic [LW-1:0] DEPTH_L = LW'(DEPTH);

  logic          pend_q, pend_d;
  logic [LW-1:0] pend_len_q, pend_len_d;
  logic [LW-1:0] act_len_q, act_len_d;
  logic [LW-1:0] ptr_q, ptr_d;
  logic          bank_q, bank_d;
  logic          urun_q, urun_d;

  logic          pend_now;
  logic [LW-1:0] len_sat;
  logic [LW-1:0] len_now;
  logic          swap;
  logic          more;

  always_comb begin
    len_sat    = (commit_len > DEPTH_L) ? DEPTH_L : commit_len;
    pend_now   = pend_q | commit;
    len_now    = commit ? len_sat : pend_len_q;
    swap       = upd_evt && pend_now;
    more       = ptr_q < act_len_q;

    pend_d     = upd_evt ? 1'b0 : pend_now;
    pend_len_d = commit ? len_sat : pend_len_q;
    act_len_d  = act_len_q;
    ptr_d      = ptr_q;
    bank_d     = bank_q;
    urun_d     = urun_q;
    act        = ACT_HOLD;
    rd_bank    = bank_q;
    rd_addr    = ptr_q[AW-1:0];

    if (swap) begin
      bank_d    = ~bank_q;
      act_len_d = len_now;
      rd_bank   = ~bank_q;
      rd_addr   = '0;
      if (len_now != '0) begin
        act    = ACT_LOAD;
        ptr_d  = LW'(1);
        urun_d = 1'b0;
      end else begin
        ptr_d  = '0;
        urun_d = 1'b1;
      end
    end else if (upd_evt) begin
      if (more) begin
        act   = ACT_LOAD;
        ptr_d = ptr_q + LW'(1);
      end else begin
        urun_d = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q     <= 1'b0;
      pend_len_q <= '0;
      act_len_q  <= '0;
      ptr_q      <= '0;
      bank_q     <= 1'b0;
      urun_q     <= 1'b0;
    end else begin
      pend_q     <= pend_d;
      pend_len_q <= pend_len_d;
      act_len_q  <= act_len_d;
      ptr_q      <= ptr_d;
      bank_q     <= bank_d;
      urun_q     <= urun_d;
    end
  end

  assign act_bank = bank_q;
  assign underrun = urun_q;

  assert_ptr_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ptr_q <= act_len_q);
  assert_urun_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (urun_q && !(upd_evt && pend_now)) |=> urun_q);
  assert_swap_toggle_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_evt && pend_now) |=> (bank_q != $past(bank_q)));
  assert_len_cap_R11: assert property (@(posedge clk) disable iff (!rst_n)
    act_len_q <= DEPTH_L);
endmodule

// File: rtl/dseq_out.sv
module dseq_out
  import dseq_pkg::*;
#(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  dseq_act_e     act,
  input  logic [DW-1:0] entry,
  input  logic [DW-1:0] period_cnt,
  output logic [DW-1:0] duty
);
  logic [DW-1:0] duty_q, duty_d;
  logic          load_en;
  logic [DW-1:0] limited;

  always_comb begin
    load_en = (act == ACT_LOAD);
    limited = (entry > period_cnt) ? period_cnt : entry;
    duty_d  = load_en ? limited : duty_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) duty_q <= '0;
    else        duty_q <= duty_d;
  end

  assign duty = duty_q;

  assert_clamp_R8: assert property (@(posedge clk) disable iff (!rst_n)
    load_en |=> duty_q <= $past(period_cnt));
endmodule

// File: rtl/pwm_duty_seq.sv
module pwm_duty_seq
  import dseq_pkg::*;
#(
  parameter int DW    = 16,
  parameter int DEPTH = 16,
  parameter int AW    = $clog2(DEPTH),
  parameter int LW    = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic          commit,
  input  logic [LW-1:0] commit_len,
  input  logic          upd_evt,
  input  logic [DW-1:0] period_cnt,
  output logic [DW-1:0] duty,
  output logic          underrun,
  output logic          active_bank
);
  dseq_act_e     act;
  logic          rd_bank;
  logic [AW-1:0] rd_addr;
  logic [DW-1:0] rd_data;
  logic          bank_cur;

  dseq_ctrl #(.DEPTH(DEPTH), .AW(AW), .LW(LW)) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .commit     (commit),
    .commit_len (commit_len),
    .upd_evt    (upd_evt),
    .act        (act),
    .rd_bank    (rd_bank),
    .rd_addr    (rd_addr),
    .act_bank   (bank_cur),
    .underrun   (underrun)
  );

  dseq_banks #(.DW(DW), .DEPTH(DEPTH), .AW(AW)) u_banks (
    .clk   (clk),
    .we    (wr_en),
    .wbank (~bank_cur),
    .waddr (wr_addr),
    .wdata (wr_data),
    .rbank (rd_bank),
    .raddr (rd_addr),
    .rdata (rd_data)
  );

  dseq_out #(.DW(DW)) u_out (
    .clk        (clk),
    .rst_n      (rst_n),
    .act        (act),
    .entry      (rd_data),
    .period_cnt (period_cnt),
    .duty       (duty)
  );

  assign active_bank = bank_cur;

  assert_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !upd_evt |=> $stable(duty));
  assert_bank_still_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !upd_evt |=> $stable(active_bank));
endmodule

// File: tb/pwm_duty_seq_bench.sv
module pwm_duty_seq_bench;
  logic        clk;
  logic        rst_n;
  logic        wr_en;
  logic [3:0]  wr_addr;
  logic [15:0] wr_data;
  logic        commit;
  logic [4:0]  commit_len;
  logic        upd_evt;
  logic [15:0] period_cnt;
  logic [15:0] duty;
  logic        underrun;
  logic        active_bank;

  int n_chk = 0;
  int n_bad = 0;

  pwm_duty_seq u_pwm_duty_seq (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .commit(commit), .commit_len(commit_len),
    .upd_evt(upd_evt), .period_cnt(period_cnt), .duty(duty),
    .underrun(underrun), .active_bank(active_bank)
  );

  // {written entry, expected duty} with period_cnt = 1000
  localparam logic [31:0] VEC [0:5] = '{
    {16'd100,   16'd100},
    {16'd2000,  16'd1000},
    {16'd0,     16'd0},
    {16'd999,   16'd999},
    {16'd1000,  16'd1000},
    {16'd65535, 16'd1000}
  };

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wr(input int a, input int d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = 4'(a); wr_data = 16'(d);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic do_commit(input int len);
    @(negedge clk);
    commit = 1'b1; commit_len = 5'(len);
    @(negedge clk);
    commit = 1'b0;
  endtask

  task automatic pulse_upd();
    @(negedge clk);
    upd_evt = 1'b1;
    @(negedge clk);
    upd_evt = 1'b0;
  endtask

  initial begin
    #2000000;
    n_bad++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; wr_en = 1'b0; wr_addr = '0; wr_data = '0;
    commit = 1'b0; commit_len = '0; upd_evt = 1'b0; period_cnt = 16'd1000;
    repeat (3) @(negedge clk);
    chk("R1 duty", duty, 0);
    chk("R1 underrun", underrun, 0);
    chk("R1 bank", active_bank, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // table-driven playback into bank 1
    for (int i = 0; i < 6; i++) wr(i, VEC[i][31:16]);
    do_commit(6);
    chk("R3 bank before strobe", active_bank, 0);
    for (int i = 0; i < 6; i++) begin
      pulse_upd();
      chk("R4 R8 table entry", duty, VEC[i][15:0]);
      chk("R6 no underrun yet", underrun, 0);
      if (i == 0) chk("R3 bank after swap", active_bank, 1);
      if (i == 2) begin
        wr(3, 7777);                 // goes to bank 0, not the playing bank
        repeat (3) @(negedge clk);
        chk("R5 held between strobes", duty, 0);
        chk("R2 bank unchanged", active_bank, 1);
      end
    end
    pulse_upd();
    chk("R6 hold last", duty, 1000);
    chk("R6 underrun set", underrun, 1);
    pulse_upd();
    repeat (4) @(negedge clk);
    chk("R7 sticky", underrun, 1);

    // latched length into bank 0
    wr(0, 11); wr(1, 22); wr(2, 33); wr(3, 44);
    do_commit(3);
    commit_len = 5'd10;
    pulse_upd();
    chk("R3 first entry", duty, 11);
    chk("R7 cleared on swap", underrun, 0);
    chk("R3 bank", active_bank, 0);
    pulse_upd(); chk("R4 second", duty, 22);
    pulse_upd(); chk("R4 third", duty, 33);
    pulse_upd();
    chk("R11 latched length hold", duty, 33);
    chk("R11 latched length underrun", underrun, 1);

    // commit and strobe in the same cycle
    wr(0, 555);
    @(negedge clk);
    commit = 1'b1; commit_len = 5'd1; upd_evt = 1'b1;
    @(negedge clk);
    commit = 1'b0; upd_evt = 1'b0;
    chk("R9 same-cycle duty", duty, 555);
    chk("R9 same-cycle bank", active_bank, 1);
    chk("R9 underrun cleared", underrun, 0);

    // clamp limit sampled on the strobe
    wr(0, 500); wr(1, 500);
    do_commit(2);
    period_cnt = 16'd300;
    pulse_upd();
    chk("R8 clamp 300", duty, 300);
    period_cnt = 16'd600;
    repeat (3) @(negedge clk);
    chk("R5 period change no effect", duty, 300);
    pulse_upd();
    chk("R8 new limit", duty, 500);

    // zero length
    do_commit(0);
    pulse_upd();
    chk("R10 bank swaps", active_bank, 1);
    chk("R10 duty holds", duty, 500);
    chk("R10 underrun", underrun, 1);

    // oversized length saturates to full depth
    period_cnt = 16'hFFFF;
    for (int i = 0; i < 16; i++) wr(i, i * 10 + 1);
    do_commit(31);
    for (int i = 0; i < 16; i++) begin
      pulse_upd();
      chk("R11 full bank entry", duty, i * 10 + 1);
      if (i == 0) chk("R7 cleared", underrun, 0);
    end
    chk("R11 no underrun at end", underrun, 0);
    pulse_upd();
    chk("R11 past depth hold", duty, 151);
    chk("R6 past depth underrun", underrun, 1);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
    $finish;
  end
endmodule